// File: doc/BRIEF.md
# Fault Latch and Drive Inhibit Gate

This block decides, every clock, whether the horizontal drive, the deflection-supply (B+) step-up converter and the vertical ramp may run. A high-voltage fault comparator flag is glitch-filtered and held in a latch. The latch stays set until software clears it or until a rail drops. The latch, the two supply-undervoltage flags, the flyback flag and three control-register enable bits feed a fixed matrix that gives one enable per output. A fault stops horizontal drive and the converter but leaves the vertical ramp running.

The converter's pulse train passes through the block. While the converter is not enabled, its drive is held low, so an external soft start can begin from a known state. The latch state is also presented as one bit for the readable status byte. All comparator flags arrive asynchronously and are passed through two-flop synchronizers. The register bits and the clear pulse are already in the clock domain.

Top module: `drive_guard`

## Requirements
- R1: The latch sets only when the synchronized fault flag has been high for at least FILT_LEN consecutive clocks. A fault pulse that lasts fewer clocks leaves the status bit at 0.
- R2: Once set, the latch stays set after the fault input returns low.
- R3: With no fault present, a one-clock clear command, or either undervoltage flag (uv12_in or uv5_in) at 1, clears the latch.
- R4: If the filtered fault is still present while a clear command is given, the set wins and the latch stays set.
- R5: hdrv_en is 1 only when both undervoltage flags are 0, the latch is clear, flyback is 0 and hdrv_en_reg is 1.
- R6: bplus_en is 1 only when both undervoltage flags are 0, the latch is clear and bplus_en_reg is 1. bplus_out follows bplus_pwm while bplus_en is 1 and is 0 otherwise.
- R7: vramp_en is 1 only when both undervoltage flags are 0 and vramp_en_reg is 1. The latch and flyback have no effect on it.
- R8: fault_status reads 1 exactly when the latch is set.
- R9: During reset and for the two clocks after reset is released, all three enables, bplus_out and fault_status are 0. The synchronized supply flags start in the undervoltage state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_in | input | 1 | High-voltage fault comparator flag, asynchronous |
| uv12_in | input | 1 | 12 V rail undervoltage flag, asynchronous, 1 = low supply |
| uv5_in | input | 1 | 5 V rail undervoltage flag, asynchronous, 1 = low supply |
| flyback_in | input | 1 | Flyback-active flag, asynchronous |
| clr_cmd | input | 1 | One-clock register-written latch clear pulse |
| hdrv_en_reg | input | 1 | Register enable for the horizontal drive |
| bplus_en_reg | input | 1 | Register enable for the B+ converter |
| vramp_en_reg | input | 1 | Register on/off bit for the vertical ramp |
| bplus_pwm | input | 1 | Converter pulse train from the pulse generator |
| hdrv_en | output | 1 | Horizontal drive enable |
| bplus_en | output | 1 | B+ converter enable |
| vramp_en | output | 1 | Vertical ramp enable |
| bplus_out | output | 1 | Gated converter drive, 0 when disabled |
| fault_status | output | 1 | Latch state for the status byte, 1 = protection active |

## Verification
The assertions assume that clr_cmd and the register enable bits are synchronous to clk. They also assume that the asynchronous flags change no more than once per clock, so each synchronizer stage carries a clean level. The stimulus changes every input just after a rising edge and holds each level for whole clocks. Fault pulses are swept in length around FILT_LEN, and the output matrix is visited over every combination of supply, flyback, latch and register state.

// File: rtl/prot_pkg.sv
package prot_pkg;

    // Asynchronous flags that pass through the synchronizer together.
    typedef struct packed {
        logic uv12;
        logic uv5;
        logic fault;
        logic fly;
    } raw_flags_t;

    // Reset value: the supplies are assumed low, so every output starts inhibited.
    localparam raw_flags_t FLAGS_RST = '{uv12: 1'b1, uv5: 1'b1, fault: 1'b0, fly: 1'b0};

    typedef struct packed {
        logic hdrv;
        logic bplus;
        logic vramp;
    } drive_t;

endpackage

// File: rtl/prot_sync.sv
module prot_sync #(
    parameter int            W       = 4,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;

    // R9: the second stage only takes over what the first stage held one clock earlier.
    a_r9_stage_order: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.s2 == $past(st_q.s1)));

endmodule

// File: rtl/prot_glitch_filter.sv
module prot_glitch_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_in,
    output logic trip
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!s_in) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trip = (st_q.cnt == LIMIT);

    // R1: the filter output can only rise after the input was high in the previous clock.
    a_r1_trip_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip) |-> $past(s_in));

    // R1: a low input drops the filter output on the next clock.
    a_r1_low_drops_trip: assert property (@(posedge clk) disable iff (!rst_n)
        !s_in |=> !trip);

endmodule

// File: rtl/prot_fault_latch.sv
module prot_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic latched
);
    typedef struct packed {
        logic hold;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_req) begin
            st_d.hold = 1'b1;
        end else if (clr_req) begin
            st_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latched = st_q.hold;

    // R2: without a clear the latch keeps its set state.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !clr_req) |=> latched);

    // R4: a set request wins over a clear in the same clock.
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> latched);

    // R3: a clear without a set empties the latch.
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> !latched);

endmodule

// File: rtl/drive_guard.sv
module drive_guard #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    input  logic uv12_in,
    input  logic uv5_in,
    input  logic flyback_in,
    input  logic clr_cmd,
    input  logic hdrv_en_reg,
    input  logic bplus_en_reg,
    input  logic vramp_en_reg,
    input  logic bplus_pwm,
    output logic hdrv_en,
    output logic bplus_en,
    output logic vramp_en,
    output logic bplus_out,
    output logic fault_status
);
    import prot_pkg::*;

    localparam int NFLAGS = $bits(raw_flags_t);

    raw_flags_t raw_flags, sync_flags;
    logic       flt_trip;
    logic       latch_q;
    logic       supply_ok;
    drive_t     drv_d;

    assign raw_flags = '{uv12: uv12_in, uv5: uv5_in, fault: fault_in, fly: flyback_in};

    prot_sync #(
        .W       (NFLAGS),
        .RST_VAL (FLAGS_RST)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_flags),
        .q     (sync_flags)
    );

    prot_glitch_filter #(
        .FILT_LEN (FILT_LEN)
    ) filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .s_in  (sync_flags.fault),
        .trip  (flt_trip)
    );

    prot_fault_latch latch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (flt_trip),
        .clr_req (clr_cmd | sync_flags.uv12 | sync_flags.uv5),
        .latched (latch_q)
    );

    // Fixed inhibit matrix: each output has its own set of inhibit sources.
    always_comb begin
        supply_ok   = !sync_flags.uv12 && !sync_flags.uv5;
        drv_d.hdrv  = supply_ok && !latch_q && !sync_flags.fly && hdrv_en_reg;
        drv_d.bplus = supply_ok && !latch_q && bplus_en_reg;
        drv_d.vramp = supply_ok && vramp_en_reg;
    end

    assign hdrv_en      = drv_d.hdrv;
    assign bplus_en     = drv_d.bplus;
    assign vramp_en     = drv_d.vramp;
    assign bplus_out    = drv_d.bplus & bplus_pwm;
    assign fault_status = latch_q;

    // R5 and R6: a set latch blocks horizontal drive and the converter.
    a_r5_latch_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fault_status |-> (!hdrv_en && !bplus_en));

    // R6: the converter drive is low whenever the converter is disabled.
    a_r6_safe_low: assert property (@(posedge clk) disable iff (!rst_n)
        !bplus_en |-> !bplus_out);

    // R8: a filtered fault shows up on the status bit one clock later.
    a_r8_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
        flt_trip |=> fault_status);

endmodule

// File: tb/drive_guard_tb_top.sv
`timescale 1ns/1ps
module drive_guard_tb_top;
    localparam int FILT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fault_in = 0, uv12_in = 0, uv5_in = 0, flyback_in = 0, clr_cmd = 0;
    logic hdrv_en_reg = 1, bplus_en_reg = 1, vramp_en_reg = 1, bplus_pwm = 1;
    logic hdrv_en, bplus_en, vramp_en, bplus_out, fault_status;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    drive_guard #(.FILT_LEN(FILT)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_in     (fault_in),
        .uv12_in      (uv12_in),
        .uv5_in       (uv5_in),
        .flyback_in   (flyback_in),
        .clr_cmd      (clr_cmd),
        .hdrv_en_reg  (hdrv_en_reg),
        .bplus_en_reg (bplus_en_reg),
        .vramp_en_reg (vramp_en_reg),
        .bplus_pwm    (bplus_pwm),
        .hdrv_en      (hdrv_en),
        .bplus_en     (bplus_en),
        .vramp_en     (vramp_en),
        .bplus_out    (bplus_out),
        .fault_status (fault_status)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic clear_latch();
        clr_cmd = 1'b1;
        step(1);
        clr_cmd = 1'b0;
        step(1);
    endtask

    task automatic fault_pulse(input int n);
        fault_in = 1'b1;
        step(n);
        fault_in = 1'b0;
        step(FILT + 4);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        step(3);
        chk("R9 hdrv in reset", hdrv_en, 1'b0);
        chk("R9 bplus in reset", bplus_en, 1'b0);
        chk("R9 vramp in reset", vramp_en, 1'b0);
        chk("R9 bplus_out in reset", bplus_out, 1'b0);
        chk("R9 status in reset", fault_status, 1'b0);
        rst_n = 1'b1;
        chk("R9 hdrv at release", hdrv_en, 1'b0);
        step(1);
        chk("R9 vramp after one clock", vramp_en, 1'b0);
        chk("R9 bplus after one clock", bplus_en, 1'b0);
        step(1);
        chk("R9 hdrv after two clocks", hdrv_en, 1'b1);
        chk("R9 vramp after two clocks", vramp_en, 1'b1);

        // R1 and R2: sweep pulse lengths around the filter length
        for (int n = 1; n <= FILT + 2; n++) begin
            clear_latch();
            chk("R3 cleared before pulse", fault_status, 1'b0);
            fault_pulse(n);
            chk("R1 pulse length decides set", fault_status, (n >= FILT));
            if (n >= FILT) begin
                chk("R2 held after input low", fault_status, 1'b1);
                chk("R5 hdrv off while latched", hdrv_en, 1'b0);
                chk("R7 vramp unaffected by latch", vramp_en, 1'b1);
            end
        end

        // R4: clear while the fault is still present
        clear_latch();
        fault_in = 1'b1;
        step(FILT + 4);
        chk("R8 status set by persistent fault", fault_status, 1'b1);
        clr_cmd = 1'b1;
        step(1);
        clr_cmd = 1'b0;
        step(1);
        chk("R4 set wins over clear", fault_status, 1'b1);
        fault_in = 1'b0;
        step(FILT + 4);
        chk("R2 still set after input low", fault_status, 1'b1);
        clear_latch();
        chk("R3 clear command empties latch", fault_status, 1'b0);

        // R3: undervoltage on either rail clears the latch
        for (int r = 0; r < 2; r++) begin
            clear_latch();
            fault_pulse(FILT + 1);
            chk("R1 set before rail drop", fault_status, 1'b1);
            if (r == 0) uv12_in = 1'b1; else uv5_in = 1'b1;
            step(3);
            uv12_in = 1'b0;
            uv5_in = 1'b0;
            step(4);
            chk("R3 rail drop clears latch", fault_status, 1'b0);
            chk("R5 hdrv back after rail recovery", hdrv_en, 1'b1);
        end

        // R5..R8: full matrix sweep
        for (int l = 0; l < 2; l++) begin
            for (int m = 0; m < 64; m++) begin
                logic u12, u5, fl, h, b, v, lat, uv;
                u12 = m[5]; u5 = m[4]; fl = m[3]; h = m[2]; b = m[1]; v = m[0];
                uv12_in = 0; uv5_in = 0; flyback_in = 0;
                step(3);
                clear_latch();
                if (l == 1) fault_pulse(FILT + 2);
                uv12_in = u12; uv5_in = u5; flyback_in = fl;
                hdrv_en_reg = h; bplus_en_reg = b; vramp_en_reg = v;
                bplus_pwm = 1'b1;
                step(4);
                uv  = u12 | u5;
                lat = (l == 1) && !uv;
                chk("R8 status in matrix", fault_status, lat);
                chk("R5 hdrv matrix", hdrv_en, !uv && !lat && !fl && h);
                chk("R6 bplus matrix", bplus_en, !uv && !lat && b);
                chk("R7 vramp matrix", vramp_en, !uv && v);
                chk("R6 bplus_out with pwm high", bplus_out, !uv && !lat && b);
                bplus_pwm = 1'b0;
                #1;
                chk("R6 bplus_out with pwm low", bplus_out, 1'b0);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule